// File: doc/BRIEF.md
# Accumulator CPU core

An 8-bit accumulator processor core. Each instruction is a 16-bit word read from a word-addressed memory that holds both code and data. The core steps every instruction through three phases, fetch, decode and execute, each lasting one clock. A one-hot ring counter tracks the phase. Combinational control logic decodes a 4-bit opcode and drives these signals:

- the instruction register load;
- the program counter increment and load;
- the accumulator load;
- the ALU function and operand select;
- the memory address select;
- the memory write strobe.

The ALU passes a value through, adds, subtracts or ANDs it with the accumulator. Results wrap modulo 256 and no carry is kept.

The core drives an 8-bit address and a write strobe, and receives a 16-bit read word. Reads are combinational: `mem_rdata` must show the word at `mem_addr` within the same cycle. A write takes effect at the rising edge that ends a cycle in which `mem_we` is high. The memory itself sits outside the core.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, the program counter, accumulator and instruction register are zero and the phase is fetch. As a result, `mem_addr` is 0 and `mem_we` is 0.
- R2: Every instruction takes exactly three cycles, fetch, decode and execute, in that order. In fetch, `mem_addr` is the program counter. In decode and execute, `mem_addr` is the instruction's operand field. The accumulator changes only at the end of an execute cycle.
- R3: The opcode is bits 15..12 of the instruction word, and the operand is bits 7..0. Bits 11..8 have no effect.
- R4: The immediate opcodes are 0000 (acc = K), 0001 (acc = acc + K), 0010 (acc = acc − K) and 0011 (acc = acc AND K), where K is the operand field.
- R5: The memory opcodes are 0100 (acc = M[A]), 0110 (acc = acc + M[A]) and 0111 (acc = acc − M[A]), where A is the operand field. Only bits 7..0 of the memory word are used.
- R6: Opcode 0101 stores the accumulator to M[A]. `mem_we` is high for exactly one cycle, the execute cycle, with `mem_addr` = A and `mem_wdata` = {8'h00, acc}.
- R7: Addition and subtraction wrap modulo 256, and no carry state is kept.
- R8: Opcode 1000 always loads the program counter with A. Opcode 1001 loads it only when acc is zero, and opcode 1010 loads it only when acc is not zero. A jump that is not taken lets execution fall through to the next word.
- R9: Opcodes 1011 through 1111 leave the accumulator and memory unchanged, and only advance the program counter.
- R10: The program counter is 8 bits wide and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Word address: program counter in fetch, operand field otherwise |
| mem_rdata | input | 16 | Word read combinationally from `mem_addr` |
| mem_wdata | output | 16 | Accumulator, zero-extended to a word |
| mem_we | output | 1 | Write strobe, high during the execute cycle of a store |

## Verification
The bench builds the core with its default widths: an 8-bit accumulator, 8-bit addresses and 16-bit words. At these widths a 256-word memory model covers the whole address space, so a program can be placed at the top of memory to make the program counter wrap. Each of the seven accumulator-writing opcodes is swept over an 8×8 grid of accumulator and operand values that includes 0, 1, 0x7F, 0x80, 0xFE and 0xFF, which reaches both wrap directions. Every jump kind is run against zero and non-zero accumulators, and every unused opcode runs with a non-zero operand.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    OPC_MOVE  = 4'h0,
    OPC_ADD   = 4'h1,
    OPC_SUB   = 4'h2,
    OPC_AND   = 4'h3,
    OPC_LOAD  = 4'h4,
    OPC_STORE = 4'h5,
    OPC_ADDM  = 4'h6,
    OPC_SUBM  = 4'h7,
    OPC_JMP   = 4'h8,
    OPC_JZ    = 4'h9,
    OPC_JNZ   = 4'hA
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_AND  = 2'd3
  } alu_fn_e;

  localparam int PHASES   = 3;
  localparam int PH_FETCH = 0;
  localparam int PH_DEC   = 1;
  localparam int PH_EXEC  = 2;

endpackage

// File: rtl/acc_cpu_ring.sv
module acc_cpu_ring #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] phase
);
  localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= START;
    else        phase <= {phase[N-2:0], phase[N-1]};
  end

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(phase)) else $error("phase not one-hot"); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    phase[N-1] |=> phase[0]) else $error("last phase not followed by fetch"); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> phase[1]) else $error("fetch not followed by decode"); // R2
endmodule

// File: rtl/acc_cpu_pc.sv
module acc_cpu_pc #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] f_step(input logic [AW-1:0] v);
    return v + ONE;
  endfunction

  logic [AW-1:0] pc_next;

  always_comb begin
    pc_next = pc;
    if (load)     pc_next = load_val;
    else if (inc) pc_next = f_step(pc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  AST_PC_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && pc == '1) |=> pc == '0) else $error("pc did not wrap"); // R10
  AST_PC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(pc)) else $error("pc moved while idle"); // R8
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] res
);
  function automatic logic [DW-1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a - b;
  endfunction

  always_comb begin
    unique case (fn)
      ALU_ADD: res = f_add(acc, opnd);
      ALU_SUB: res = f_sub(acc, opnd);
      ALU_AND: res = acc & opnd;
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [PHASES-1:0] phase,
  input  logic [3:0]        opc,
  input  logic [DW-1:0]     acc,
  output logic              ir_we,
  output logic              pc_inc,
  output logic              pc_load,
  output logic              acc_we,
  output alu_fn_e           alu_fn,
  output logic              opnd_mem,
  output logic              addr_ir,
  output logic              mem_we
);
  logic acc_zero;
  logic is_exec;
  logic writes_acc;
  logic take;
  logic is_store;

  assign acc_zero = (acc == '0);
  assign is_exec  = phase[PH_EXEC];

  always_comb begin
    writes_acc = 1'b0;
    take       = 1'b0;
    is_store   = 1'b0;
    alu_fn     = ALU_PASS;
    opnd_mem   = 1'b0;
    case (opcode_e'(opc))
      OPC_MOVE:  writes_acc = 1'b1;
      OPC_ADD:   begin writes_acc = 1'b1; alu_fn = ALU_ADD; end
      OPC_SUB:   begin writes_acc = 1'b1; alu_fn = ALU_SUB; end
      OPC_AND:   begin writes_acc = 1'b1; alu_fn = ALU_AND; end
      OPC_LOAD:  begin writes_acc = 1'b1; opnd_mem = 1'b1; end
      OPC_ADDM:  begin writes_acc = 1'b1; opnd_mem = 1'b1; alu_fn = ALU_ADD; end
      OPC_SUBM:  begin writes_acc = 1'b1; opnd_mem = 1'b1; alu_fn = ALU_SUB; end
      OPC_STORE: is_store = 1'b1;
      OPC_JMP:   take = 1'b1;
      OPC_JZ:    take = acc_zero;
      OPC_JNZ:   take = !acc_zero;
      default:   ;
    endcase
  end

  assign ir_we   = phase[PH_FETCH];
  assign pc_inc  = phase[PH_FETCH];
  assign addr_ir = !phase[PH_FETCH];
  assign acc_we  = is_exec && writes_acc;
  assign pc_load = is_exec && take;
  assign mem_we  = is_exec && is_store;

  AST_CTRL_EXCLUSIVE: assert final ($countones({acc_we, pc_load, mem_we}) <= 1)
    else $error("more than one execute action"); // R9
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [IW-1:0] mem_rdata,
  output logic [IW-1:0] mem_wdata,
  output logic          mem_we
);
  localparam int OPC_LO = IW - 4;

  logic [PHASES-1:0] phase;
  logic [IW-1:0]     ir;
  logic [DW-1:0]     acc;
  logic [AW-1:0]     pc;
  logic [DW-1:0]     alu_b;
  logic [DW-1:0]     alu_y;
  alu_fn_e           alu_fn;
  logic ir_we, pc_inc, pc_load, acc_we, opnd_mem, addr_ir, store_we;

  acc_cpu_ring #(.N(PHASES)) ring_i (
    .clk(clk), .rst_n(rst_n), .phase(phase)
  );

  acc_cpu_ctrl #(.DW(DW)) ctrl_i (
    .phase(phase), .opc(ir[IW-1:OPC_LO]), .acc(acc),
    .ir_we(ir_we), .pc_inc(pc_inc), .pc_load(pc_load), .acc_we(acc_we),
    .alu_fn(alu_fn), .opnd_mem(opnd_mem), .addr_ir(addr_ir), .mem_we(store_we)
  );

  acc_cpu_pc #(.AW(AW)) pc_i (
    .clk(clk), .rst_n(rst_n), .inc(pc_inc), .load(pc_load),
    .load_val(ir[AW-1:0]), .pc(pc)
  );

  assign alu_b = opnd_mem ? mem_rdata[DW-1:0] : ir[DW-1:0];

  acc_cpu_alu #(.DW(DW)) alu_i (
    .fn(alu_fn), .acc(acc), .opnd(alu_b), .res(alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir <= '0;
    else if (ir_we) ir <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (acc_we) acc <= alu_y;
  end

  assign mem_addr  = addr_ir ? ir[AW-1:0] : pc;
  assign mem_wdata = {{(IW-DW){1'b0}}, acc};
  assign mem_we    = store_we;

  AST_ACC_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[PH_EXEC] |=> $stable(acc)) else $error("acc changed outside execute"); // R2
  AST_IR_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[PH_FETCH] |=> $stable(ir)) else $error("ir changed outside fetch"); // R2
  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == ir[AW-1:0] && phase[PH_EXEC])) else $error("store address wrong"); // R6
  AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[PH_EXEC] && ir[IW-1:OPC_LO] == OPC_JZ && acc == '0) |=> pc == $past(ir[AW-1:0]))
    else $error("jump on zero not taken"); // R8
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[PH_EXEC] && ir[IW-1:OPC_LO] > 4'hA) |-> !mem_we) else $error("unused opcode wrote memory"); // R9
endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam logic [7:0] RES_AD = 8'hF0;
  localparam logic [7:0] DAT_AD = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_we;

  logic [15:0] mem [256];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_a = '0;
  logic [15:0] tb_d = '0;
  int tests = 0, fails = 0, cyc = 0, we_cnt = 0;
  logic [7:0] we_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk) begin
    if (!rst_n) we_cnt <= 0;
    else if (mem_we) begin we_cnt <= we_cnt + 1; we_addr <= mem_addr; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: all requirements, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [7:0] opnd);
    return {op, 4'h9, opnd}; // R3: bits 11..8 always non-zero
  endfunction

  function automatic int exp_alu(input int op, input int a, input int b);
    case (op)
      1, 6:    return (a + b) % 256;
      2, 7:    return (a - b + 256) % 256;
      3:       return a & b;
      default: return b;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic run_edges(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  int ops[7] = '{0, 1, 2, 3, 4, 6, 7};
  int vals[8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h55, 8'hAA};

  initial begin
    // R1 and R2: reset state and phase addressing
    hold_reset();
    put(8'h00, ins(4'h0, 8'h3C));
    put(8'h01, ins(4'h8, 8'h01));
    #1;
    chk("R1 reset mem_addr", mem_addr, 0);
    chk("R1 reset mem_we", mem_we, 0);
    chk("R1 reset mem_wdata", mem_wdata, 0);
    run_edges(1);
    chk("R2 decode addr", mem_addr, 8'h3C);
    @(posedge clk); #1;
    chk("R2 execute addr", mem_addr, 8'h3C);
    @(posedge clk); #1;
    chk("R2 next fetch addr", mem_addr, 8'h01);
    chk("R2 acc after execute", mem_wdata, 8'h3C);

    // R4 R5 R6 R7: ALU opcode sweep
    foreach (ops[k]) begin
      foreach (vals[i]) begin
        foreach (vals[j]) begin
          automatic int op = ops[k];
          automatic int a = vals[i];
          automatic int b = vals[j];
          automatic int e = exp_alu(op, a, b);
          automatic string rq;
          hold_reset();
          put(8'h00, ins(4'h0, a[7:0]));
          put(8'h01, ins(op[3:0], (op >= 4) ? DAT_AD : b[7:0]));
          put(8'h02, ins(4'h5, RES_AD));
          put(8'h03, ins(4'h8, 8'h03));
          put(DAT_AD, {8'hA5, b[7:0]});
          put(RES_AD, 16'hDEAD);
          run_edges(10);
          if ((op == 1 || op == 6) && a + b > 255) rq = "R7 add wrap";
          else if ((op == 2 || op == 7) && a < b) rq = "R7 sub wrap";
          else if (op >= 4) rq = "R5 memory operand";
          else rq = "R4 immediate";
          chk(rq, mem[RES_AD], e);
          if (i == 0 && j == 0) begin
            chk("R6 single write", we_cnt, 1);
            chk("R6 write address", we_addr, RES_AD);
          end
        end
      end
    end

    // R8: jumps
    for (int jo = 8; jo <= 10; jo++) begin
      foreach (vals[i]) begin
        automatic int a = vals[i];
        automatic bit tk = (jo == 8) || (jo == 9 && a == 0) || (jo == 10 && a != 0);
        hold_reset();
        put(8'h00, ins(4'h0, a[7:0]));
        put(8'h01, ins(jo[3:0], 8'h04));
        put(8'h02, ins(4'h0, 8'h11));
        put(8'h03, ins(4'h8, 8'h05));
        put(8'h04, ins(4'h0, 8'h22));
        put(8'h05, ins(4'h5, RES_AD));
        put(8'h06, ins(4'h8, 8'h06));
        put(RES_AD, 16'hDEAD);
        run_edges(16);
        chk("R8 jump decision", mem[RES_AD], tk ? 8'h22 : 8'h11);
      end
    end

    // R9: unused opcodes
    for (int no = 11; no <= 15; no++) begin
      hold_reset();
      put(8'h00, ins(4'h0, 8'h6B));
      put(8'h01, ins(no[3:0], 8'h33));
      put(8'h02, ins(4'h5, RES_AD));
      put(8'h03, ins(4'h8, 8'h03));
      put(8'h33, 16'h0077);
      put(RES_AD, 16'hDEAD);
      run_edges(10);
      chk("R9 no-op keeps acc", mem[RES_AD], 8'h6B);
      chk("R9 no-op no extra write", we_cnt, 1);
      chk("R9 no-op leaves operand word", mem[8'h33], 16'h0077);
    end

    // R10: program counter wrap
    hold_reset();
    put(8'h00, ins(4'h8, 8'hFE));
    put(8'hFE, ins(4'h0, 8'h5A));
    put(8'hFF, ins(4'h5, RES_AD));
    put(RES_AD, 16'hDEAD);
    run_edges(6);
    chk("R10 fetch at top word", mem_addr, 8'hFF);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 fetch after wrap", mem_addr, 8'h00);
    chk("R10 store before wrap", mem[RES_AD], 8'h5A);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule